// File: doc/BRIEF.md
# Strobe-Sequenced Serial Memory Host Engine

This block is the master side of a narrow memory bus made of chip enable, output enable, write enable and one bidirectional data bit (all enables active low). The attached memory has no serial clock. Every bit moves in its own bus cycle: a write cycle latches the data bit, and a read cycle returns one bit. The engine turns byte-level commands into those long single-bit cycle trains, and it frames each transfer with the in-band patterns the memory expects.

Commands arrive on a valid/ready port. A read fetches one or more bytes starting at an address. A page write stores 1 to 8 bytes inside one 8-byte page. A poll watches the busy indication of a nonvolatile write. Results leave on a valid/ready response port. A response is either a data byte or a completion code. Each bit cycle has two phases. In the setup phase chip enable is high and the data bit is driven for writes. In the strobe phase chip enable and exactly one strobe are low. The clock count of each phase is a parameter.

Top module: `serbus_host`

## Requirements
- R1: After reset, all three enables are high, the data bit is not driven, `rsp_valid` is low and `cmd_ready` is high. `cmd_ready` stays low from the cycle after a command is accepted until the command's last response has been taken.
- R2: Write enable and output enable are never low together. Neither of them is low while chip enable is high.
- R3: Each bus cycle has exactly one falling edge of chip enable. Chip enable is high for at least the cycle after it rises, so that consecutive bit cycles stay separated.
- R4: Every accepted read or page write begins with three cycles in this order: a read, a write of 0, and a read.
- R5: After those three cycles come 16 write cycles that carry the address, most significant bit first. The 7 upper bits are 0 and the 9-bit `cmd_addr` fills the rest.
- R6: A read (`cmd_op`=0) of N bytes, where N is at least 1, issues 8×N read cycles after the address. It returns N responses of kind 0 (data), each byte assembled with the first bit read as bit 7.
- R7: A page write (`cmd_op`=1) sends `cmd_len` bytes as write cycles with no read between them. Byte i is `cmd_wdata[8i+7:8i]`, sent for i = 0 upward, most significant bit first. The write then issues a read, a write of 1 and a read, and returns one response of kind 1 (done).
- R8: The engine returns one response of kind 2 (error) and issues no bus cycle in these cases: a page write whose `cmd_len` is 0 or greater than 8, a page write whose `cmd_addr[2:0]` plus `cmd_len` exceeds 8, a read of length 0, or `cmd_op`=3.
- R9: A poll (`cmd_op`=2) issues read cycles only. It returns kind 1 at the first read that yields 1. If `POLL_MAX` reads all yield 0, it returns kind 3 (timeout).
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response kind and data stay constant and no bus cycle starts.
- R11: The data bit is driven during every write strobe and released during every read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken this cycle |
| cmd_op | input | 2 | 0 read, 1 page write, 2 poll, 3 invalid |
| cmd_addr | input | 9 | Byte address |
| cmd_len | input | LEN_W | Byte count |
| cmd_wdata | input | 64 | Page data, byte i in bits 8i+7:8i |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_kind | output | 2 | 0 data, 1 done, 2 error, 3 timeout |
| rsp_data | output | 8 | Read byte for kind 0 |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_dq_out | output | 1 | Data bit toward memory |
| bus_dq_oe | output | 1 | Drive enable for the data bit |
| bus_dq_in | input | 1 | Data bit from memory |

## Verification
The assertions check the strobe rules on every cycle: the enables are never low together, no strobe is active without chip enable, the data bit is driven only during writes, and chip enable stays high for a cycle between strokes. They also check that a stalled response holds steady and that the poll counter stays inside its bound. Only the bench's scenarios can show whether the cycle trains are right: the framing triads, the address and data bit order, the page-boundary rejections, the byte assembly and the poll outcomes. For these the bench records every strobe at the pins and compares the record against a list it builds for each command.

// File: rtl/srb_pkg.sv
package srb_pkg;

    localparam int MEM_AW     = 9;
    localparam int FRAME_AW   = 16;
    localparam int PAGE_BYTES = 8;

    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_POLL  = 2'd2;

    typedef enum logic [1:0] {
        RSP_DATA = 2'd0,
        RSP_DONE = 2'd1,
        RSP_ERR  = 2'd2,
        RSP_TMO  = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE
    } phase_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE,
        SQ_ADDR,
        SQ_RDAT,
        SQ_WDAT,
        SQ_POST,
        SQ_POLL,
        SQ_RESP
    } seq_e;

    typedef struct packed {
        logic wr;
        logic bit_v;
    } cyc_t;

    function automatic logic page_ok(input int unsigned lo, input int unsigned n);
        return (n != 0) && (n <= PAGE_BYTES) && (lo + n <= PAGE_BYTES);
    endfunction

endpackage

// File: rtl/srb_cycle.sv
module srb_cycle
    import srb_pkg::*;
#(
    parameter int T_SETUP  = 2,
    parameter int T_STROBE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  cyc_t req_c,
    output logic done,
    output logic rbit,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic dq_o,
    output logic dq_oe,
    input  logic dq_i
);
    localparam int TMAX = (T_SETUP > T_STROBE) ? T_SETUP : T_STROBE;
    localparam int CW   = $clog2(TMAX + 1);

    phase_e        ph;
    logic [CW-1:0] cnt;
    cyc_t          cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            done <= 1'b0;
            rbit <= 1'b0;
            cur  <= '0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: if (req && !done) begin
                    cur <= req_c;
                    cnt <= '0;
                    ph  <= PH_SETUP;
                end
                PH_SETUP: if (cnt == CW'(T_SETUP - 1)) begin
                    cnt <= '0;
                    ph  <= PH_STROBE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_STROBE: if (cnt == CW'(T_STROBE - 1)) begin
                    ph   <= PH_IDLE;
                    done <= 1'b1;
                    rbit <= dq_i;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ce_n  = (ph != PH_STROBE);
        we_n  = !((ph == PH_STROBE) && cur.wr);
        oe_n  = !((ph == PH_STROBE) && !cur.wr);
        dq_oe = (ph != PH_IDLE) && cur.wr;
        dq_o  = cur.bit_v;
    end

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n));
    p_strobe_ce_r2: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !oe_n) |-> !ce_n);
    p_ce_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_n) |=> ce_n);
    p_rd_float_r11: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !dq_oe);
    p_wr_drive_r11: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> dq_oe);

endmodule

// File: rtl/srb_seq.sv
module srb_seq
    import srb_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int POLL_MAX = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [MEM_AW-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [63:0]       cmd_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_kind,
    output logic [7:0]        rsp_data,
    output logic              cyc_req,
    output cyc_t              cyc_c,
    input  logic              cyc_done,
    input  logic              cyc_rbit
);
    localparam int PCW = $clog2(POLL_MAX + 1);

    seq_e              st;
    logic              wr_q;
    logic [MEM_AW-1:0] addr_q;
    logic [3:0]        len_q;
    logic [LEN_W-1:0]  left_q;
    logic [63:0]       wdata_q;
    logic [6:0]        idx;
    logic [PCW-1:0]    pcnt;
    logic [7:0]        shreg;
    rsp_kind_e         kind_q;
    logic [7:0]        data_q;
    logic [FRAME_AW-1:0] addr16;

    assign cmd_ready = (st == SQ_IDLE);
    assign rsp_valid = (st == SQ_RESP);
    assign rsp_kind  = kind_q;
    assign rsp_data  = data_q;
    assign addr16    = FRAME_AW'(addr_q);

    always_comb begin
        cyc_req = 1'b0;
        cyc_c   = '0;
        case (st)
            SQ_PRE:  begin cyc_req = 1'b1; cyc_c.wr = (idx == 7'd1); cyc_c.bit_v = 1'b0; end
            SQ_POST: begin cyc_req = 1'b1; cyc_c.wr = (idx == 7'd1); cyc_c.bit_v = 1'b1; end
            SQ_ADDR: begin cyc_req = 1'b1; cyc_c.wr = 1'b1; cyc_c.bit_v = addr16[4'd15 - idx[3:0]]; end
            SQ_WDAT: begin cyc_req = 1'b1; cyc_c.wr = 1'b1; cyc_c.bit_v = wdata_q[{idx[5:3], ~idx[2:0]}]; end
            SQ_RDAT, SQ_POLL: cyc_req = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            len_q   <= '0;
            left_q  <= '0;
            wdata_q <= '0;
            idx     <= '0;
            pcnt    <= '0;
            shreg   <= '0;
            kind_q  <= RSP_DATA;
            data_q  <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (cmd_valid) begin
                    wr_q    <= (cmd_op == OP_WRITE);
                    addr_q  <= cmd_addr;
                    len_q   <= cmd_len[3:0];
                    wdata_q <= cmd_wdata;
                    idx     <= '0;
                    pcnt    <= '0;
                    left_q  <= '0;
                    data_q  <= '0;
                    if (cmd_op == OP_READ && cmd_len != '0) begin
                        left_q <= cmd_len;
                        st     <= SQ_PRE;
                    end else if (cmd_op == OP_WRITE &&
                                 page_ok(int'(cmd_addr[2:0]), int'(cmd_len))) begin
                        st <= SQ_PRE;
                    end else if (cmd_op == OP_POLL) begin
                        st <= SQ_POLL;
                    end else begin
                        kind_q <= RSP_ERR;
                        st     <= SQ_RESP;
                    end
                end
                SQ_PRE: if (cyc_done) begin
                    if (idx == 7'd2) begin idx <= '0; st <= SQ_ADDR; end
                    else idx <= idx + 1'b1;
                end
                SQ_ADDR: if (cyc_done) begin
                    if (idx == 7'd15) begin idx <= '0; st <= wr_q ? SQ_WDAT : SQ_RDAT; end
                    else idx <= idx + 1'b1;
                end
                SQ_WDAT: if (cyc_done) begin
                    if (idx == {len_q - 4'd1, 3'b111}) begin idx <= '0; st <= SQ_POST; end
                    else idx <= idx + 1'b1;
                end
                SQ_POST: if (cyc_done) begin
                    if (idx == 7'd2) begin
                        idx    <= '0;
                        kind_q <= RSP_DONE;
                        st     <= SQ_RESP;
                    end else idx <= idx + 1'b1;
                end
                SQ_RDAT: if (cyc_done) begin
                    shreg <= {shreg[6:0], cyc_rbit};
                    if (idx == 7'd7) begin
                        idx    <= '0;
                        data_q <= {shreg[6:0], cyc_rbit};
                        kind_q <= RSP_DATA;
                        left_q <= left_q - 1'b1;
                        st     <= SQ_RESP;
                    end else idx <= idx + 1'b1;
                end
                SQ_POLL: if (cyc_done) begin
                    if (cyc_rbit) begin
                        kind_q <= RSP_DONE;
                        st     <= SQ_RESP;
                    end else if (pcnt == PCW'(POLL_MAX - 1)) begin
                        kind_q <= RSP_TMO;
                        st     <= SQ_RESP;
                    end else pcnt <= pcnt + 1'b1;
                end
                SQ_RESP: if (rsp_ready) begin
                    st <= (left_q != '0) ? SQ_RDAT : SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_data)));
    p_rsp_stall_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cyc_req);
    p_poll_bound_r9: assert property (@(posedge clk) disable iff (rst)
        pcnt < PCW'(POLL_MAX));

endmodule

// File: rtl/serbus_host.sv
module serbus_host
    import srb_pkg::*;
#(
    parameter int T_SETUP  = 2,
    parameter int T_STROBE = 2,
    parameter int LEN_W    = 8,
    parameter int POLL_MAX = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [MEM_AW-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [63:0]       cmd_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_kind,
    output logic [7:0]        rsp_data,
    output logic              bus_ce_n,
    output logic              bus_oe_n,
    output logic              bus_we_n,
    output logic              bus_dq_out,
    output logic              bus_dq_oe,
    input  logic              bus_dq_in
);
    logic cyc_req, cyc_done, cyc_rbit;
    cyc_t cyc_c;

    srb_seq #(.LEN_W(LEN_W), .POLL_MAX(POLL_MAX)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_kind(rsp_kind), .rsp_data(rsp_data),
        .cyc_req(cyc_req), .cyc_c(cyc_c), .cyc_done(cyc_done), .cyc_rbit(cyc_rbit)
    );

    srb_cycle #(.T_SETUP(T_SETUP), .T_STROBE(T_STROBE)) u_cyc (
        .clk(clk), .rst(rst),
        .req(cyc_req), .req_c(cyc_c), .done(cyc_done), .rbit(cyc_rbit),
        .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
        .dq_o(bus_dq_out), .dq_oe(bus_dq_oe), .dq_i(bus_dq_in)
    );

endmodule

// File: tb/test_serbus_host.sv
`timescale 1ns/1ps
module test_serbus_host;
    localparam int POLLM = 16;

    typedef struct packed {
        logic [1:0]  op;
        logic [8:0]  addr;
        logic [7:0]  len;
        logic [63:0] wdata;
        logic [7:0]  busy;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 9'h005, 8'd1, 64'h0,                  8'd0,   2'd0},
        '{2'd0, 9'h1FF, 8'd3, 64'h0,                  8'd0,   2'd0},
        '{2'd1, 9'h010, 8'd8, 64'h0123456789ABCDEF,   8'd0,   2'd1},
        '{2'd1, 9'h0A3, 8'd3, 64'h0000000000C35A81,   8'd0,   2'd1},
        '{2'd1, 9'h0A6, 8'd3, 64'h0000000000FFFFFF,   8'd0,   2'd2},
        '{2'd1, 9'h0A0, 8'd0, 64'h0,                  8'd0,   2'd2},
        '{2'd2, 9'h000, 8'd0, 64'h0,                  8'd4,   2'd1},
        '{2'd2, 9'h000, 8'd0, 64'h0,                  8'd200, 2'd3},
        '{2'd0, 9'h020, 8'd0, 64'h0,                  8'd0,   2'd2},
        '{2'd1, 9'h1FF, 8'd1, 64'h00000000000000B6,   8'd0,   2'd1},
        '{2'd1, 9'h008, 8'd9, 64'hFFFFFFFFFFFFFFFF,   8'd0,   2'd2},
        '{2'd3, 9'h000, 8'd1, 64'h0,                  8'd0,   2'd2}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_ready;
    logic [1:0] cmd_op = '0;
    logic [8:0] cmd_addr = '0;
    logic [7:0] cmd_len = '0;
    logic [63:0] cmd_wdata = '0;
    logic rsp_valid, rsp_ready = 1'b0;
    logic [1:0] rsp_kind;
    logic [7:0] rsp_data;
    logic bus_ce_n, bus_oe_n, bus_we_n, bus_dq_out, bus_dq_oe;
    logic bus_dq_in = 1'b1;

    always #2.5 clk = ~clk;

    serbus_host #(.T_SETUP(2), .T_STROBE(2), .LEN_W(8), .POLL_MAX(POLLM)) i_serbus_host (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_kind(rsp_kind), .rsp_data(rsp_data),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in)
    );

    int n_cmp = 0, n_bad = 0, cycles = 0;

    // bus monitor and memory stand-in
    logic logw [2048];
    logic logb [2048];
    logic elw  [2048];
    logic elb  [2048];
    int nlog = 0, nread = 0, ce_falls = 0, rbase = 0, k = 0, ne = 0;
    logic pce = 1'b1, pwe = 1'b1, poe = 1'b1;
    logic [1:0] cur_op = '0;
    logic [8:0] cur_addr = '0;
    logic [7:0] cur_busy = '0;

    function automatic logic [7:0] memb(input int a);
        return 8'(((a % 512) * 37) + 8'h5A);
    endfunction

    function automatic logic rdval(input int i);
        if (cur_op == 2'd2) return (i >= int'(cur_busy));
        if (cur_op == 2'd0 && i >= 2) begin
            logic [7:0] b;
            b = memb(int'(cur_addr) + (i - 2) / 8);
            return b[7 - ((i - 2) % 8)];
        end
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (pce && !bus_ce_n) ce_falls++;
            if (pwe && !bus_we_n) begin
                logw[nlog % 2048] = 1'b1; logb[nlog % 2048] = bus_dq_out; nlog++;
            end
            if (poe && !bus_oe_n) begin
                k = nread - rbase;
                bus_dq_in = rdval(k);
                logw[nlog % 2048] = 1'b0; logb[nlog % 2048] = 1'b0;
                nread++; nlog++;
            end
        end
        pce = bus_ce_n; pwe = bus_we_n; poe = bus_oe_n;
    end

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic w, input logic b);
        elw[ne] = w; elb[ne] = b; ne++;
    endtask

    task automatic build_exp(input vec_t v);
        logic [15:0] a16;
        ne = 0;
        a16 = {7'b0, v.addr};
        if (v.kind == 2'd2) return;
        if (v.op == 2'd2) begin
            for (int i = 0; i < ((v.kind == 2'd1) ? int'(v.busy) + 1 : POLLM); i++) push(1'b0, 1'b0);
            return;
        end
        push(1'b0, 1'b0); push(1'b1, 1'b0); push(1'b0, 1'b0);
        for (int i = 15; i >= 0; i--) push(1'b1, a16[i]);
        if (v.op == 2'd0) begin
            for (int i = 0; i < 8 * int'(v.len); i++) push(1'b0, 1'b0);
        end else begin
            for (int by = 0; by < int'(v.len); by++)
                for (int bt = 7; bt >= 0; bt--) push(1'b1, v.wdata[by * 8 + bt]);
            push(1'b0, 1'b0); push(1'b1, 1'b1); push(1'b0, 1'b0);
        end
    endtask

    function automatic string tagof(input vec_t v);
        if (v.kind == 2'd2) return "R8";
        if (v.op == 2'd2) return "R9";
        if (v.op == 2'd0) return "R4/R5/R6";
        return "R4/R5/R7";
    endfunction

    task automatic run_vec(input int vi);
        vec_t v;
        int lbase, cbase, nrsp, bad, stall_log;
        logic [7:0] held_d;
        logic [1:0] held_k;
        v = VECS[vi];
        cur_op = v.op; cur_addr = v.addr; cur_busy = v.busy;
        lbase = nlog; cbase = ce_falls; rbase = nread;
        build_exp(v);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = v.op; cmd_addr = v.addr; cmd_len = v.len; cmd_wdata = v.wdata;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R1", "cmd_ready while busy", int'(cmd_ready), 0);
        nrsp = (v.kind == 2'd0) ? int'(v.len) : 1;
        for (int j = 0; j < nrsp; j++) begin
            while (!rsp_valid) @(negedge clk);
            if (vi == 1 && j == 0) begin
                held_d = rsp_data; held_k = rsp_kind; stall_log = nlog;
                repeat (6) @(negedge clk);
                check(rsp_valid && rsp_data == held_d && rsp_kind == held_k && nlog == stall_log,
                      "R10", "response held under stall", int'(rsp_data), int'(held_d));
            end
            check(rsp_kind == v.kind, tagof(v), "response kind", int'(rsp_kind), int'(v.kind));
            if (v.kind == 2'd0)
                check(rsp_data == memb(int'(v.addr) + j), "R6", "read byte",
                      int'(rsp_data), int'(memb(int'(v.addr) + j)));
            rsp_ready = 1'b1;
            @(negedge clk);
            rsp_ready = 1'b0;
        end
        while (!cmd_ready) @(negedge clk);
        check(nlog - lbase == ne, tagof(v), "bus cycle count", nlog - lbase, ne);
        bad = 0;
        for (int i = 0; i < ne && i < nlog - lbase; i++)
            if (logw[(lbase + i) % 2048] != elw[i] || logb[(lbase + i) % 2048] != elb[i]) bad++;
        check(bad == 0, tagof(v), "bus cycle content mismatches", bad, 0);
        check(ce_falls - cbase == nlog - lbase, "R3", "chip enable falls per bus cycle",
              ce_falls - cbase, nlog - lbase);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_ready && !rsp_valid, "R1", "ready/valid after reset",
              {cmd_ready, rsp_valid}, 2'b10);
        check(bus_ce_n && bus_oe_n && bus_we_n && !bus_dq_oe, "R1", "bus idle after reset",
              {bus_ce_n, bus_oe_n, bus_we_n, bus_dq_oe}, 4'b1110);
        for (int vi = 0; vi < NV; vi++) run_vec(vi);
        // directed: reset in the middle of a read returns the bus to idle
        @(negedge clk);
        cur_op = 2'd0; cur_addr = 9'h033; rbase = nread;
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 9'h033; cmd_len = 8'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_ready && !rsp_valid && bus_ce_n && bus_oe_n && bus_we_n && !bus_dq_oe,
              "R1", "idle after mid-command reset",
              {cmd_ready, rsp_valid, bus_ce_n, bus_oe_n, bus_we_n, bus_dq_oe}, 6'b101110);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule